// File: doc/BRIEF.md
# Scan-Friendly Reset Synchronizer

This block turns an active-low asynchronous reset pin into the internal reset that feeds a clock domain's downstream flops. The reset is applied to the domain immediately, but it is only removed in step with the functional clock, through a short chain of flops. Each flop in that chain is a scan flop: a multiplexer on its input chooses between the functional value and a scan input. The chain's last flop drives the scan output.

When the chip is under scan test, the internal reset must not disturb shifting. A build-time parameter `MODE` chooses one of three ways to handle the internal reset in test.

- **Mux (`MODE` = 0):** when the test-mode strap is set, the reset pin is routed straight to the internal reset.
- **Injector (`MODE` = 1):** when the test-mode strap is set, the internal reset is held at its inactive level.
- **Gated (`MODE` = 2):** the internal reset is held inactive only while scan-enable is high. During capture the synchronizer output drives the internal reset line, so faults on that line can be tested.

`STAGES` sets the chain length. It defaults to two.

Top module: `rsync_scan_top`

## Requirements
- R1: While `rst_ni` is low, every chain flop clears at once, with no clock edge needed. `rst_int_no` is low unless a test treatment overrides it: `MODE` 0 with `test_mode_i` high still follows the pin, so it is low too; `MODE` 1 with `test_mode_i` high gives high; `MODE` 2 with `scan_en_i` high gives high.
- R2: Take `rst_ni` rising with `scan_en_i` low and no override active. `rst_int_no` stays low after the first rising `clk_i` edge and is high after the second.
- R3: While `rst_ni` is high and `scan_en_i` is low, the first flop loads 1 and each later flop loads its predecessor. The last flop is visible on `scan_out_o`.
- R4: While `scan_en_i` is high, each edge shifts `scan_in_i` into the first flop and moves every flop's value to the next one. A bit applied at `scan_in_i` appears on `scan_out_o` after `STAGES` edges.
- R5: In `MODE` 0, with `test_mode_i` high, `rst_int_no` equals `rst_ni` combinationally, with no clock delay.
- R6: In `MODE` 0 and `MODE` 1, with `test_mode_i` low, `rst_int_no` equals the last chain flop.
- R7: In `MODE` 1, with `test_mode_i` high, `rst_int_no` is 1 whatever `rst_ni`, `scan_en_i` and the chain hold.
- R8: In `MODE` 2, whenever `scan_en_i` is high, `rst_int_no` is 1, whether or not test mode is set.
- R9: In `MODE` 2, whenever `scan_en_i` is low, `rst_int_no` equals the last chain flop. This holds with `test_mode_i` high, so a value shifted into the chain reaches `rst_int_no` as soon as scan-enable falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Functional clock that releases the reset and shifts the scan chain |
| rst_ni | input | 1 | Primary reset pin, active low, asynchronous |
| test_mode_i | input | 1 | Test-mode strap |
| scan_en_i | input | 1 | Scan-enable: high selects shift |
| scan_in_i | input | 1 | Serial scan data into the first chain flop |
| scan_out_o | output | 1 | Serial scan data from the last chain flop |
| rst_int_no | output | 1 | Internal reset for downstream flops, active low |

## Verification
The assertions are checked on every cycle and cover these behaviours:
- the chain clears while the pin is low;
- the first flop loads 1 in functional operation;
- each flop copies its neighbour on every edge;
- scan data enters the first flop;
- each test treatment forces or passes the internal reset as its mode requires.

Some properties involve timing across several cycles, and only the bench scenarios can show them:
- the two-edge release delay;
- a pattern travelling from scan input to scan output;
- the instant effect of a reset asserted between clock edges;
- the capture-phase sequence in gated mode, in which a shifted-in zero appears on the internal reset and then clears after two functional edges.

// File: rtl/rsync_pkg.sv
package rsync_pkg;

    typedef enum int unsigned {
        RS_MUX    = 0,
        RS_INJECT = 1,
        RS_GATED  = 2
    } rs_mode_e;

    localparam int unsigned RS_MODE_COUNT = 3;

    typedef struct packed {
        logic q;
    } rs_bit_t;

endpackage

// File: rtl/rsync_scan_ff.sv
module rsync_scan_ff
    import rsync_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic se_i,
    input  logic si_i,
    input  logic d_i,
    output logic q_o
);

    rs_bit_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.q = se_i ? si_i : d_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.q;

endmodule

// File: rtl/rsync_chain.sv
module rsync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scan_en_i,
    input  logic scan_in_i,
    output logic sync_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] stage_q;
    logic [STAGES-1:0] func_d;
    logic [STAGES-1:0] scan_d;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign func_d[i] = 1'b1;
            assign scan_d[i] = scan_in_i;

            // R3: the head flop loads the inactive level when not shifting
            a_r3_head_loads_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
                !scan_en_i |=> stage_q[i]);

            // R4: the head flop captures the serial input when shifting
            a_r4_head_takes_scan_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
                scan_en_i |=> (stage_q[i] == $past(scan_in_i)));
        end else begin : g_tail
            assign func_d[i] = stage_q[i-1];
            assign scan_d[i] = stage_q[i-1];

            // R3 and R4: a later flop copies its predecessor in both modes
            a_r4_stage_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
                1'b1 |=> (stage_q[i] == $past(stage_q[i-1])));
        end

        rsync_scan_ff u_ff (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .se_i   (scan_en_i),
            .si_i   (scan_d[i]),
            .d_i    (func_d[i]),
            .q_o    (stage_q[i])
        );
    end

    assign sync_o = stage_q[LAST];

    // R1: the chain is clear whenever the pin holds reset
    always @(negedge clk_i) begin
        if (!rst_ni) begin
            a_r1_chain_cleared: assert (stage_q == '0)
                else $error("chain not cleared during reset");
        end
    end

endmodule

// File: rtl/rsync_test_ctrl.sv
module rsync_test_ctrl
    import rsync_pkg::*;
#(
    parameter int unsigned MODE = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic test_mode_i,
    input  logic scan_en_i,
    input  logic sync_i,
    output logic rst_n_o
);

    logic rst_n_d;

    if (MODE == int'(RS_MUX)) begin : g_mux
        always_comb begin
            rst_n_d = test_mode_i ? rst_ni : sync_i;
        end

        // R5: test mode routes the pin straight through
        always @(negedge clk_i) begin
            if (test_mode_i) begin
                a_r5_pin_passthrough: assert (rst_n_o == rst_ni)
                    else $error("mux mode does not follow the pin");
            end else begin
                a_r6_mux_functional: assert (rst_n_o == sync_i)
                    else $error("mux mode does not follow the chain");
            end
        end
    end else if (MODE == int'(RS_INJECT)) begin : g_inject
        always_comb begin
            rst_n_d = test_mode_i ? 1'b1 : sync_i;
        end

        // R7: test mode holds the line inactive
        always @(negedge clk_i) begin
            if (test_mode_i) begin
                a_r7_held_inactive: assert (rst_n_o)
                    else $error("injector lets reset through in test mode");
            end else begin
                a_r6_inject_functional: assert (rst_n_o == sync_i)
                    else $error("injector does not follow the chain");
            end
        end
    end else if (MODE == int'(RS_GATED)) begin : g_gated
        always_comb begin
            rst_n_d = sync_i | scan_en_i;
        end

        // R8 and R9: shift forces inactive, capture hands control to the chain
        always @(negedge clk_i) begin
            if (scan_en_i) begin
                a_r8_shift_inactive: assert (rst_n_o)
                    else $error("gated mode asserts reset during shift");
            end else begin
                a_r9_capture_follows: assert (rst_n_o == sync_i)
                    else $error("gated mode ignores the chain during capture");
            end
        end
    end else begin : g_bad_mode
        $error("MODE must be below %0d", RS_MODE_COUNT);
        assign rst_n_d = sync_i;
    end

    assign rst_n_o = rst_n_d;

    // R1: with no override active, a held pin keeps the line asserted
    always @(negedge clk_i) begin
        if (!rst_ni && !test_mode_i && !scan_en_i) begin
            a_r1_line_asserted: assert (!rst_n_o)
                else $error("internal reset released while pin is low");
        end
    end

endmodule

// File: rtl/rsync_scan_top.sv
module rsync_scan_top
    import rsync_pkg::*;
#(
    parameter int unsigned MODE   = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic test_mode_i,
    input  logic scan_en_i,
    input  logic scan_in_i,
    output logic scan_out_o,
    output logic rst_int_no
);

    logic sync_q;

    rsync_chain #(
        .STAGES (STAGES)
    ) u_chain (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .scan_en_i (scan_en_i),
        .scan_in_i (scan_in_i),
        .sync_o    (sync_q)
    );

    rsync_test_ctrl #(
        .MODE (MODE)
    ) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .test_mode_i (test_mode_i),
        .scan_en_i   (scan_en_i),
        .sync_i      (sync_q),
        .rst_n_o     (rst_int_no)
    );

    assign scan_out_o = sync_q;

endmodule

// File: tb/rsync_scan_top_tb.sv
`timescale 1ns/1ps
module rsync_scan_top_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tm = 1'b0;
    logic se = 1'b0;
    logic si = 1'b0;
    logic so_g, ri_g, so_m, ri_m, so_i, ri_i;
    int   vectors = 0;
    int   misses = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    rsync_scan_top #(.MODE(2), .STAGES(2)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .test_mode_i(tm), .scan_en_i(se),
        .scan_in_i(si), .scan_out_o(so_g), .rst_int_no(ri_g));

    rsync_scan_top #(.MODE(0), .STAGES(2)) u_dut_mux (
        .clk_i(clk), .rst_ni(rst_n), .test_mode_i(tm), .scan_en_i(se),
        .scan_in_i(si), .scan_out_o(so_m), .rst_int_no(ri_m));

    rsync_scan_top #(.MODE(1), .STAGES(2)) u_dut_inj (
        .clk_i(clk), .rst_ni(rst_n), .test_mode_i(tm), .scan_en_i(se),
        .scan_in_i(si), .scan_out_o(so_i), .rst_int_no(ri_i));

    // behavioural reference: a queue of chain contents, head first
    bit ref_q[$] = '{1'b0, 1'b0};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q = '{1'b0, 1'b0};
        end else begin
            void'(ref_q.pop_back());
            ref_q.push_front(se ? si : 1'b1);
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            check("R4 scan_out gated", so_g, ref_q[1]);
            check("R3 scan_out mux", so_m, ref_q[1]);
            check("R3 scan_out inject", so_i, ref_q[1]);
            check("R5 mux line", ri_m, tm ? rst_n : ref_q[1]);
            check("R7 inject line", ri_i, tm ? 1'b1 : ref_q[1]);
            check("R9 gated line", ri_g, se ? 1'b1 : ref_q[1]);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R1: reset state
        repeat (3) step();
        #1;
        check("R1 reset scan_out", so_g, 1'b0);
        check("R1 reset gated", ri_g, 1'b0);
        check("R1 reset mux", ri_m, 1'b0);
        check("R1 reset inject", ri_i, 1'b0);

        // R2: release takes two edges
        step();
        rst_n = 1'b1;
        step();
        #1;
        check("R2 low after one edge", ri_g, 1'b0);
        step();
        #1;
        check("R2 high after two edges", ri_g, 1'b1);
        check("R6 mux follows chain", ri_m, 1'b1);
        check("R6 inject follows chain", ri_i, 1'b1);
        check("R3 functional load", so_g, 1'b1);

        // R1: assertion between edges takes effect at once
        rst_n = 1'b0;
        #0.5;
        check("R1 async gated", ri_g, 1'b0);
        check("R1 async mux", ri_m, 1'b0);
        check("R1 async inject", ri_i, 1'b0);
        check("R1 async chain", so_g, 1'b0);
        step();
        rst_n = 1'b1;
        repeat (2) step();

        // R4, R7, R8: shift in test mode
        tm = 1'b1;
        se = 1'b1;
        si = 1'b0;
        step();
        step();
        si = 1'b1;
        step();
        si = 1'b0;
        step();
        check("R4 bit arrives after two edges", so_g, 1'b1);
        check("R8 shift holds gated inactive", ri_g, 1'b1);
        check("R7 inject held", ri_i, 1'b1);
        step();
        check("R4 next bit", so_g, 1'b0);
        check("R7 inject held with zero chain", ri_i, 1'b1);
        check("R8 gated held with zero chain", ri_g, 1'b1);

        // R5: pin passes straight through in mux mode
        rst_n = 1'b0;
        #0.5;
        check("R5 pin low passes", ri_m, 1'b0);
        check("R7 inject ignores pin", ri_i, 1'b1);
        check("R8 gated ignores pin in shift", ri_g, 1'b1);
        rst_n = 1'b1;
        #0.5;
        check("R5 pin high passes", ri_m, 1'b1);
        step();

        // R9: capture hands the line to the chain
        si = 1'b0;
        step();
        step();
        se = 1'b0;
        #0.5;
        check("R9 shifted zero drives line", ri_g, 1'b0);
        check("R7 inject stays high in capture", ri_i, 1'b1);
        step();
        #1;
        check("R9 still low after one edge", ri_g, 1'b0);
        step();
        #1;
        check("R9 released after two edges", ri_g, 1'b1);

        // R6: leave test mode, functional path again
        tm = 1'b0;
        step();
        check("R6 mux functional", ri_m, 1'b1);
        check("R6 inject functional", ri_i, 1'b1);
        repeat (4) step();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            misses++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule